// File: doc/BRIEF.md
# Serial-Shared Memory Self-Test Wrapper

This wrapper runs a march test over several single-port SRAMs that share one data width and one clock, treating them as a single logical memory. The address counter carries extra high-order select bits. They are decoded one-hot into per-memory chip enables, so the memories are exercised strictly one after another. One data generator and one response analyzer, each of the common data width, serve every memory. Peak test power is therefore that of one memory rather than the sum of all of them.

Each memory may have its own depth. A select region ends at that memory's own last word, and the walk then moves to the next memory. Ascending elements run from word 0 of memory 0 up to the last word of the last memory. Descending elements run the same path in reverse. The march is 8N long: up(w0); up(r0,w1,r1); down(r1,w0,r0); down(r0). A full pass therefore takes eight times the summed depths in cycles.

When the test mode is off, every memory is driven straight from its own functional inputs and the wrapper is invisible. A sticky fail flag records any miscompare. A small register keeps the select value of the first failing read, which identifies the faulty memory.

Top module: `mbist_serial_wrap`

## Requirements
- R1: With test_mode_i low, mem_ce_o, mem_we_o, mem_addr_o and mem_wdata_o equal the matching func_* inputs in the same cycle, and start_i has no effect (done_o stays 0).
- R2: With test_mode_i high, at most one bit of mem_ce_o is 1 in any cycle, and the functional inputs are ignored. Every memory sees the same address, write enable and write data.
- R3: An ascending element visits memory 0 words 0 to D0-1, then memory 1 words 0 to D1-1, and so on up to the last memory. Di is that memory's depth parameter, and no address at or above Di reaches memory i.
- R4: A descending element visits the last memory from word D-1 down to 0, then each lower memory in turn, and ends at word 0 of memory 0.
- R5: The operation order is: element 0 ascending writes 0; element 1 ascending reads 0, writes 1, reads 1 at each word; element 2 descending reads 1, writes 0, reads 0 at each word; element 3 descending reads 0. Data 0 is all bits 0 and data 1 is all bits 1.
- R6: done_o rises exactly 8*(sum of depths)+1 rising edges after the edge that samples an accepted start_i. It then holds until the next accepted start, and a start_i pulse during a run is ignored.
- R7: fail_o is set when read data from the selected memory, presented in the cycle after the read, differs from the expected value. It stays set until an accepted start, which clears it.
- R8: fail_mem_o holds the select index (0-based memory number) of the first failing read of a run, and later failures do not change it.
- R9: Read data of memories that were not selected has no effect on fail_o.
- R10: After reset, done_o, fail_o and fail_mem_o are 0 and no chip enable is driven in test mode while idle.
- R11: A miscompare on the final read of the run (word 0 of memory 0) appears on fail_o in the same cycle that done_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by wrapper and memories |
| rst_ni | input | 1 | Asynchronous reset, active low |
| test_mode_i | input | 1 | 1 selects self-test control of the memories |
| start_i | input | 1 | Starts a run when idle or done, in test mode |
| done_o | output | 1 | Run complete, held until the next start |
| fail_o | output | 1 | Sticky miscompare flag |
| fail_mem_o | output | SEL_W | Memory index of the first miscompare |
| func_ce_i | input | NUM_MEMS | Functional chip enables |
| func_we_i | input | NUM_MEMS | Functional write enables |
| func_addr_i | input | NUM_MEMS*ADDR_W | Functional addresses, memory m at slice m |
| func_wdata_i | input | NUM_MEMS*DATA_W | Functional write data, memory m at slice m |
| mem_ce_o | output | NUM_MEMS | Chip enable to each memory |
| mem_we_o | output | NUM_MEMS | Write enable to each memory |
| mem_addr_o | output | NUM_MEMS*ADDR_W | Address to each memory |
| mem_wdata_o | output | NUM_MEMS*DATA_W | Write data to each memory |
| mem_rdata_i | input | NUM_MEMS*DATA_W | Read data from each memory, one cycle after the read |

## Verification
The main collision is the last comparison of a run meeting the completion flag. The final read targets word 0 of memory 0, and its result is judged on the same edge that raises done_o. The bench arms a read fault that strikes only that last operation. It then checks that fail_o is still 0 one cycle before done_o and that fail_o, fail_mem_o and done_o all change together. A second overlap is a start pulse landing mid-run. Here the scoreboard's full operation order and the unchanged completion cycle must both survive.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_DONE
  } mb_state_e;

  typedef struct packed {
    logic we;
    logic val;
  } mb_op_t;

  localparam logic [1:0] LAST_ELEM = 2'd3;

  // index of the final operation inside an element
  function automatic logic [1:0] elem_last_op(input logic [1:0] e);
    case (e)
      2'd1, 2'd2: return 2'd2;
      default:    return 2'd0;
    endcase
  endfunction

  function automatic logic elem_down(input logic [1:0] e);
    return e[1];
  endfunction

  function automatic mb_op_t elem_op(input logic [1:0] e, input logic [1:0] i);
    mb_op_t o;
    o = '{we: 1'b0, val: 1'b0};
    case (e)
      2'd0: o = '{we: 1'b1, val: 1'b0};
      2'd1: case (i)
              2'd0:    o = '{we: 1'b0, val: 1'b0};
              2'd1:    o = '{we: 1'b1, val: 1'b1};
              default: o = '{we: 1'b0, val: 1'b1};
            endcase
      2'd2: case (i)
              2'd0:    o = '{we: 1'b0, val: 1'b1};
              2'd1:    o = '{we: 1'b1, val: 1'b0};
              default: o = '{we: 1'b0, val: 1'b0};
            endcase
      default: o = '{we: 1'b0, val: 1'b0};
    endcase
    return o;
  endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
  parameter int unsigned NUM_MEMS = 4,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned DEPTHS [NUM_MEMS] = '{default: 32}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_dn_i,
  input  logic              step_i,
  input  logic              dn_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] word_o,
  output logic              end_o
);

  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_MEMS - 1);

  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] word_q;
  logic              at_top;

  function automatic logic [ADDR_W-1:0] top_word(input logic [SEL_W-1:0] s);
    return ADDR_W'(DEPTHS[s] - 1);
  endfunction

  always_comb begin
    at_top = (word_q == top_word(sel_q));
    end_o  = dn_i ? (word_q == '0 && sel_q == '0) : (at_top && sel_q == SEL_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      word_q <= '0;
    end else if (load_i) begin
      if (load_dn_i) begin
        sel_q  <= SEL_MAX;
        word_q <= top_word(SEL_MAX);
      end else begin
        sel_q  <= '0;
        word_q <= '0;
      end
    end else if (step_i) begin
      if (dn_i) begin
        if (word_q == '0) begin
          sel_q  <= sel_q - 1'b1;
          word_q <= top_word(sel_q - 1'b1);
        end else begin
          word_q <= word_q - 1'b1;
        end
      end else begin
        if (at_top) begin
          sel_q  <= sel_q + 1'b1;
          word_q <= '0;
        end else begin
          word_q <= word_q + 1'b1;
        end
      end
    end
  end

  assign sel_o  = sel_q;
  assign word_o = word_q;

endmodule

// File: rtl/mbist_march_seq.sv
module mbist_march_seq
  import mbist_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic addr_end_i,
  output logic go_o,
  output logic load_o,
  output logic load_dn_o,
  output logic step_o,
  output logic dn_o,
  output logic active_o,
  output logic op_we_o,
  output logic op_val_o,
  output logic done_o
);

  mb_state_e  st_q;
  logic [1:0] elem_q, idx_q;
  logic       last_op, elem_end;
  mb_op_t     op;

  always_comb begin
    op        = elem_op(elem_q, idx_q);
    active_o  = (st_q == ST_RUN);
    go_o      = start_i && (st_q == ST_IDLE || st_q == ST_DONE);
    last_op   = (idx_q == elem_last_op(elem_q));
    elem_end  = active_o && last_op && addr_end_i;
    dn_o      = elem_down(elem_q);
    step_o    = active_o && last_op && !addr_end_i;
    load_o    = go_o || (elem_end && elem_q != LAST_ELEM);
    load_dn_o = go_o ? 1'b0 : elem_down(elem_q + 2'd1);
    op_we_o   = op.we;
    op_val_o  = op.val;
    done_o    = (st_q == ST_DONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      elem_q <= '0;
      idx_q  <= '0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (last_op) begin
            idx_q <= '0;
            if (addr_end_i) begin
              if (elem_q == LAST_ELEM) st_q <= ST_DRAIN;
              else                     elem_q <= elem_q + 2'd1;
            end
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        ST_DRAIN: st_q <= ST_DONE;
        default: if (go_o) begin
          st_q   <= ST_RUN;
          elem_q <= '0;
          idx_q  <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mbist_resp.sv
module mbist_resp #(
  parameter int unsigned NUM_MEMS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SEL_W    = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       rd_i,
  input  logic [DATA_W-1:0]          exp_i,
  input  logic [SEL_W-1:0]           sel_i,
  input  logic [NUM_MEMS*DATA_W-1:0] rdata_i,
  output logic                       fail_o,
  output logic [SEL_W-1:0]           fail_sel_o
);

  logic              rd_q, fail_q, miss;
  logic [DATA_W-1:0] exp_q, got;
  logic [SEL_W-1:0]  sel_q, fail_sel_q;

  always_comb begin
    got  = rdata_i[int'(sel_q)*DATA_W +: DATA_W];
    miss = rd_q && (got != exp_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= 1'b0;
      exp_q      <= '0;
      sel_q      <= '0;
      fail_q     <= 1'b0;
      fail_sel_q <= '0;
    end else begin
      rd_q  <= rd_i;
      exp_q <= exp_i;
      sel_q <= sel_i;
      if (clear_i) begin
        fail_q     <= 1'b0;
        fail_sel_q <= '0;
      end else if (miss && !fail_q) begin
        fail_q     <= 1'b1;
        fail_sel_q <= sel_q;
      end
    end
  end

  assign fail_o     = fail_q;
  assign fail_sel_o = fail_sel_q;

endmodule

// File: rtl/mbist_serial_wrap.sv
module mbist_serial_wrap #(
  parameter int unsigned NUM_MEMS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DEPTHS [NUM_MEMS] = '{default: 32},
  localparam int unsigned SEL_W   = $clog2(NUM_MEMS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       test_mode_i,
  input  logic                       start_i,
  output logic                       done_o,
  output logic                       fail_o,
  output logic [SEL_W-1:0]           fail_mem_o,
  input  logic [NUM_MEMS-1:0]        func_ce_i,
  input  logic [NUM_MEMS-1:0]        func_we_i,
  input  logic [NUM_MEMS*ADDR_W-1:0] func_addr_i,
  input  logic [NUM_MEMS*DATA_W-1:0] func_wdata_i,
  output logic [NUM_MEMS-1:0]        mem_ce_o,
  output logic [NUM_MEMS-1:0]        mem_we_o,
  output logic [NUM_MEMS*ADDR_W-1:0] mem_addr_o,
  output logic [NUM_MEMS*DATA_W-1:0] mem_wdata_o,
  input  logic [NUM_MEMS*DATA_W-1:0] mem_rdata_i
);

  logic              go, load, load_dn, step, dn, active, op_we, op_val, addr_end;
  logic [SEL_W-1:0]  bist_sel;
  logic [ADDR_W-1:0] bist_word;
  logic [DATA_W-1:0] bist_data;

  mbist_march_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i && test_mode_i),
    .addr_end_i (addr_end),
    .go_o       (go),
    .load_o     (load),
    .load_dn_o  (load_dn),
    .step_o     (step),
    .dn_o       (dn),
    .active_o   (active),
    .op_we_o    (op_we),
    .op_val_o   (op_val),
    .done_o     (done_o)
  );

  mbist_addr_gen #(
    .NUM_MEMS (NUM_MEMS),
    .ADDR_W   (ADDR_W),
    .SEL_W    (SEL_W),
    .DEPTHS   (DEPTHS)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_dn_i (load_dn),
    .step_i    (step),
    .dn_i      (dn),
    .sel_o     (bist_sel),
    .word_o    (bist_word),
    .end_o     (addr_end)
  );

  assign bist_data = {DATA_W{op_val}};

  mbist_resp #(
    .NUM_MEMS (NUM_MEMS),
    .DATA_W   (DATA_W),
    .SEL_W    (SEL_W)
  ) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (go),
    .rd_i       (active && !op_we),
    .exp_i      (bist_data),
    .sel_i      (bist_sel),
    .rdata_i    (mem_rdata_i),
    .fail_o     (fail_o),
    .fail_sel_o (fail_mem_o)
  );

  for (genvar g = 0; g < NUM_MEMS; g++) begin : g_mem
    assign mem_ce_o[g] = test_mode_i ? (active && bist_sel == SEL_W'(g)) : func_ce_i[g];
    assign mem_we_o[g] = test_mode_i ? op_we : func_we_i[g];
    assign mem_addr_o[g*ADDR_W +: ADDR_W] =
      test_mode_i ? bist_word : func_addr_i[g*ADDR_W +: ADDR_W];
    assign mem_wdata_o[g*DATA_W +: DATA_W] =
      test_mode_i ? bist_data : func_wdata_i[g*DATA_W +: DATA_W];
  end

endmodule

// File: rtl/mbist_serial_wrap_chk.sv
module mbist_serial_wrap_chk #(
  parameter int unsigned NUM_MEMS = 4,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned SEL_W    = 2,
  parameter int unsigned DEPTHS [NUM_MEMS] = '{default: 32}
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       test_mode_i,
  input logic                       start_i,
  input logic                       done_o,
  input logic                       fail_o,
  input logic [SEL_W-1:0]           fail_mem_o,
  input logic [NUM_MEMS-1:0]        func_ce_i,
  input logic [NUM_MEMS-1:0]        mem_ce_o,
  input logic [NUM_MEMS*ADDR_W-1:0] mem_addr_o
);

  logic restart;
  assign restart = start_i && test_mode_i;

  // R1
  func_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_i |-> mem_ce_o == func_ce_i);

  // R2
  one_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i |-> $onehot0(mem_ce_o));

  // R6
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !restart |=> done_o);

  // R10
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode_i && done_o |-> mem_ce_o == '0);

  // R7
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !restart |=> fail_o);

  // R8
  fail_mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !restart |=> $stable(fail_mem_o));

  for (genvar g = 0; g < NUM_MEMS; g++) begin : g_rng
    // R3
    addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      test_mode_i && mem_ce_o[g] |-> int'(mem_addr_o[g*ADDR_W +: ADDR_W]) < int'(DEPTHS[g]));
  end

endmodule

bind mbist_serial_wrap mbist_serial_wrap_chk #(
  .NUM_MEMS (NUM_MEMS),
  .ADDR_W   (ADDR_W),
  .SEL_W    (SEL_W),
  .DEPTHS   (DEPTHS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .test_mode_i (test_mode_i),
  .start_i     (start_i),
  .done_o      (done_o),
  .fail_o      (fail_o),
  .fail_mem_o  (fail_mem_o),
  .func_ce_i   (func_ce_i),
  .mem_ce_o    (mem_ce_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/tb_mbist_serial_wrap.sv
`timescale 1ns/1ps
module tb_mbist_serial_wrap;

  localparam int N   = 4;
  localparam int DW  = 8;
  localparam int AW  = 5;
  localparam int SW  = 2;
  localparam int unsigned DEP [N] = '{32, 20, 32, 12};
  localparam int SUM = 96;
  localparam int OPS = 8 * SUM;

  logic clk_i = 1'b0, rst_ni = 1'b0, test_mode_i = 1'b1, start_i = 1'b0;
  logic done_o, fail_o;
  logic [SW-1:0]   fail_mem_o;
  logic [N-1:0]    func_ce_i = '1, func_we_i = '0;
  logic [N*AW-1:0] func_addr_i = '0;
  logic [N*DW-1:0] func_wdata_i = '0;
  logic [N-1:0]    mem_ce_o, mem_we_o;
  logic [N*AW-1:0] mem_addr_o;
  logic [N*DW-1:0] mem_wdata_o, mem_rdata_i;

  always #2 clk_i = ~clk_i;

  mbist_serial_wrap #(.NUM_MEMS(N), .DATA_W(DW), .ADDR_W(AW), .DEPTHS(DEP)) dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // memory models with read-fault slots
  logic [DW-1:0] mem [N][32];
  logic [DW-1:0] rd [N];
  bit f_en [2];
  int f_mem [2], f_addr [2];
  int f_from = 0;
  int op_n = 0;

  always_comb for (int m = 0; m < N; m++) mem_rdata_i[m*DW +: DW] = rd[m];

  always @(posedge clk_i) begin
    for (int m = 0; m < N; m++) begin
      int a;
      logic [DW-1:0] v;
      a = int'(mem_addr_o[m*AW +: AW]);
      if (mem_ce_o[m]) begin
        if (mem_we_o[m]) mem[m][a] <= mem_wdata_o[m*DW +: DW];
        else begin
          v = mem[m][a];
          for (int f = 0; f < 2; f++)
            if (f_en[f] && f_mem[f] == m && f_addr[f] == a && op_n >= f_from) v = v ^ 8'h01;
          rd[m] <= v;
        end
      end else rd[m] <= 8'h5A ^ DW'(m);
    end
    if (test_mode_i && |mem_ce_o) op_n <= op_n + 1;
  end

  // scoreboard
  typedef struct { int sel; int addr; bit we; bit val; } exp_t;
  exp_t q[$];

  function automatic int n_ops(int e);
    return (e == 1 || e == 2) ? 3 : 1;
  endfunction

  function automatic bit op_we(int e, int i);
    return (e == 0) || (i == 1 && (e == 1 || e == 2));
  endfunction

  function automatic bit op_val(int e, int i);
    if (e == 1) return i != 0;
    if (e == 2) return i == 0;
    return 1'b0;
  endfunction

  task automatic push_march();
    for (int e = 0; e < 4; e++) begin
      for (int k = 0; k < N; k++) begin
        int m;
        m = (e < 2) ? k : N - 1 - k;
        for (int j = 0; j < int'(DEP[m]); j++) begin
          int w;
          w = (e < 2) ? j : int'(DEP[m]) - 1 - j;
          for (int i = 0; i < n_ops(e); i++) q.push_back('{m, w, op_we(e, i), op_val(e, i)});
        end
      end
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && test_mode_i && |mem_ce_o) begin
      exp_t x;
      int s;
      checks++;
      s = 0;
      for (int m = 0; m < N; m++) if (mem_ce_o[m]) s = m;
      if ($countones(mem_ce_o) != 1) begin
        errors++;
        $display("FAIL R2 ce=%b expected one-hot", mem_ce_o);
      end else if (q.size() == 0) begin
        errors++;
        $display("FAIL R5 extra op sel=%0d addr=%0d expected none", s, mem_addr_o[s*AW +: AW]);
      end else begin
        x = q.pop_front();
        for (int m = 1; m < N; m++)
          if (mem_addr_o[m*AW +: AW] != mem_addr_o[0 +: AW] || mem_wdata_o[m*DW +: DW] != mem_wdata_o[0 +: DW]) begin
            errors++;
            $display("FAIL R2 shared lines differ at mem %0d: addr %0d vs %0d", m, mem_addr_o[m*AW +: AW], mem_addr_o[0 +: AW]);
          end
        if (s != x.sel || int'(mem_addr_o[s*AW +: AW]) != x.addr || mem_we_o[s] != x.we ||
            mem_wdata_o[s*DW +: DW] != {DW{x.val}}) begin
          errors++;
          $display("FAIL R3/R4/R5 got sel=%0d addr=%0d we=%0d d=%h expected sel=%0d addr=%0d we=%0d d=%h",
                   s, mem_addr_o[s*AW +: AW], mem_we_o[s], mem_wdata_o[s*DW +: DW],
                   x.sel, x.addr, x.we, {DW{x.val}});
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_bist(bit mid_start, bit late, bit exp_fail, int exp_sel);
    int n;
    bit pre_fail;
    push_march();
    f_from = late ? op_n + OPS - 1 : 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk(done_o == 1'b0, "R6 done cleared by start", int'(done_o), 0);
    chk(fail_o == 1'b0, "R7 fail cleared by start", int'(fail_o), 0);
    n = 0;
    pre_fail = 0;
    while (!done_o && n < OPS + 20) begin
      if (mid_start && n == 100) start_i = 1'b1;
      if (n == 101) start_i = 1'b0;
      pre_fail = fail_o;
      @(negedge clk_i);
      n++;
    end
    chk(n == OPS + 1, "R6 done latency", n, OPS + 1);
    chk(q.size() == 0, "R5 all ops issued", q.size(), 0);
    q.delete();
    chk(fail_o == exp_fail, "R7 fail result", int'(fail_o), int'(exp_fail));
    if (exp_fail) chk(int'(fail_mem_o) == exp_sel, "R8 first failing memory", int'(fail_mem_o), exp_sel);
    if (late) begin
      chk(pre_fail == 1'b0, "R11 fail low before done", int'(pre_fail), 0);
      chk(fail_o == 1'b1 && int'(fail_mem_o) == 0, "R11 fail with done", int'(fail_o), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    f_en = '{0, 0};
    f_mem = '{0, 0};
    f_addr = '{0, 0};
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10
    chk(done_o == 0, "R10 done after reset", int'(done_o), 0);
    chk(fail_o == 0, "R10 fail after reset", int'(fail_o), 0);
    chk(fail_mem_o == 0, "R10 fail_mem after reset", int'(fail_mem_o), 0);
    chk(mem_ce_o == 0, "R10 R2 no ce when idle", int'(mem_ce_o), 0);

    // R1 functional pass-through, start ignored
    test_mode_i = 1'b0;
    func_ce_i = 4'b1010;
    func_we_i = 4'b0110;
    func_addr_i = 20'h5_3A71;
    func_wdata_i = 32'hC3A5_1E77;
    #1;
    chk(mem_ce_o == func_ce_i, "R1 ce pass", int'(mem_ce_o), int'(func_ce_i));
    chk(mem_we_o == func_we_i, "R1 we pass", int'(mem_we_o), int'(func_we_i));
    chk(mem_addr_o == func_addr_i, "R1 addr pass", int'(mem_addr_o), int'(func_addr_i));
    chk(mem_wdata_o == func_wdata_i, "R1 wdata pass", int'(mem_wdata_o), int'(func_wdata_i));
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    chk(done_o == 0, "R1 start ignored", int'(done_o), 0);
    chk(mem_ce_o == func_ce_i, "R1 ce still functional", int'(mem_ce_o), int'(func_ce_i));
    func_ce_i = '1;
    func_we_i = '1;
    test_mode_i = 1'b1;
    @(negedge clk_i);

    // clean run, mid-run start, foreign read data ignored (R9)
    run_bist(1, 0, 0, 0);
    repeat (10) @(negedge clk_i);
    chk(done_o == 1, "R6 done held", int'(done_o), 1);

    // two faults: memory 2 fails before memory 3 (R8)
    f_en = '{1, 1};
    f_mem = '{2, 3};
    f_addr = '{5, 0};
    run_bist(0, 0, 1, 2);
    repeat (4) @(negedge clk_i);
    chk(fail_o == 1 && fail_mem_o == 2, "R7 R8 fail held", int'(fail_mem_o), 2);

    // restart without faults clears the flag (R7)
    f_en = '{0, 0};
    run_bist(0, 0, 0, 0);

    // fault at last word of a short memory (R3 boundary, R8)
    f_en = '{1, 1};
    f_mem = '{1, 3};
    f_addr = '{19, 0};
    run_bist(0, 0, 1, 1);

    // fault striking only the final read (R11)
    f_en = '{1, 0};
    f_mem = '{0, 0};
    f_addr = '{0, 0};
    run_bist(0, 1, 1, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule